// File: doc/BRIEF.md
# Video Capture Event Interrupt Unit

This block watches the progress of a video input capture and turns three kinds of capture event into one level-sensitive interrupt request. The events are: a finished field while capture is on, the capture reaching a programmed line while memory writes are idle, and an overflow of the capture buffers. A pixel-write strobe delivers the line and column of each pixel that the capture path writes. The block keeps the most recent position so that software can read it.

Software uses a small register bus with two locations. The control location holds a capture-enable bit, one interrupt-enable bit for each event, and the line threshold. The same location also takes write-one acknowledge bits and a soft-reset bit. These last bits are not stored and always read back as zero. The status location is read-only. It returns the three event flags together with the last column and line written. The interrupt stays high while any event that is both pending and enabled remains uncleared.

The threshold event does not depend on capture enable. Software can therefore count fields down to a chosen line without polling. The event waits until a write-idle input reports that every pixel write issued so far has completed. It is then raised at most once per field.

Top module: `vcap_irq_unit`

## Requirements
- R1: After the synchronous reset, the control readback, the status readback and `irq` are all zero.
- R2: A `field_done` pulse sets the capture-complete flag (status bit 0) only when capture enable (control bit 0) is 1. With capture disabled, the flag is left unchanged.
- R3: The threshold flag (status bit 1) is set one clock after two conditions both hold: a pixel strobe in the current field has had a line number at or above the threshold (control bits 27:16), and `wr_idle` is high. It is set at most once per field, and `field_done` rearms it. Capture enable has no effect on it. While `wr_idle` is low, the flag is not set.
- R4: A `buf_ovf` pulse sets the overflow flag (status bit 2). A pixel strobe in the same cycle still updates the reported position.
- R5: Each pixel strobe stores its column in status bits 15:4 and its line in status bits 27:16. Both are 12-bit values, readable on the following cycle.
- R6: `irq` is high exactly when some flag is set and its enable is also set. The enables are control bit 1 for capture complete, bit 2 for threshold and bit 3 for overflow. Flags are readable even when their enable is 0.
- R7: A control write with 1 in an acknowledge bit clears that flag at the same edge. The acknowledge bits are bit 4 for capture complete, bit 5 for threshold and bit 6 for overflow. `irq` is therefore low on the cycle after the last enabled flag is acknowledged. A 0 in an acknowledge bit leaves the flag as it is.
- R8: If an event occurs in the same cycle as the write that acknowledges it, the flag stays set.
- R9: A control write with bit 7 set clears all flags, the stored position and the threshold tracking at that edge. The other control fields are taken from the same write.
- R10: Control readback returns capture enable, the three interrupt enables and the threshold at their written positions. Bits 4 to 7 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_vld | input | 1 | Pixel-write strobe |
| pix_x | input | 12 | Column of the strobed pixel |
| pix_y | input | 12 | Line of the strobed pixel |
| field_done | input | 1 | End-of-field pulse |
| buf_ovf | input | 1 | Capture buffer overflow pulse |
| wr_idle | input | 1 | High when all issued pixel writes have completed |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on address |
| irq | output | 1 | Level interrupt request |

## Verification
The bench uses the default parameters: a 2-bit register address with control at 0 and status at 1, and the package's 12-bit coordinates. These values let the bench drive both the all-ones column and a line just below a threshold of 0x800. At that width, the threshold comparison and the position field packing can be reached in only a few pixel strobes. Holding `wr_idle` low for several cycles shows that the threshold event waits for write completion. Driving acknowledge writes in the same cycle as overflow pulses and field ends shows which action takes priority.

// File: rtl/vcap_irq_pkg.sv
package vcap_irq_pkg;

    localparam int COORD_W = 12;
    localparam int DATA_W  = 32;
    localparam int NUM_EVT = 3;

    // event indices into flag, enable and acknowledge vectors
    localparam int EV_CC  = 0;
    localparam int EV_THR = 1;
    localparam int EV_HBE = 2;

    // control register field positions
    localparam int CTL_CAPEN_BIT = 0;
    localparam int CTL_IE_LSB    = 1;
    localparam int CTL_ACK_LSB   = CTL_IE_LSB + NUM_EVT;
    localparam int CTL_SRST_BIT  = CTL_ACK_LSB + NUM_EVT;
    localparam int CTL_THR_LSB   = 16;

    // status register field positions
    localparam int STS_FLAG_LSB = 0;
    localparam int STS_X_LSB    = 4;
    localparam int STS_Y_LSB    = 16;

    typedef logic [NUM_EVT-1:0] evt_vec_t;
    typedef logic [COORD_W-1:0] coord_t;

    typedef struct packed {
        logic     cap_en;
        evt_vec_t ie;
        coord_t   y_thr;
    } ctrl_t;

    typedef struct packed {
        coord_t x;
        coord_t y;
    } pos_t;

    typedef struct packed {
        logic     wr;
        evt_vec_t ack;
        logic     srst;
    } ctl_cmd_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CTL_CAPEN_BIT] = c.cap_en;
        w[CTL_IE_LSB +: NUM_EVT] = c.ie;
        w[CTL_THR_LSB +: COORD_W] = c.y_thr;
        return w;
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.cap_en = w[CTL_CAPEN_BIT];
        c.ie     = w[CTL_IE_LSB +: NUM_EVT];
        c.y_thr  = w[CTL_THR_LSB +: COORD_W];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_status(input evt_vec_t f, input pos_t p);
        logic [DATA_W-1:0] w;
        w = '0;
        w[STS_FLAG_LSB +: NUM_EVT] = f;
        w[STS_X_LSB +: COORD_W] = p.x;
        w[STS_Y_LSB +: COORD_W] = p.y;
        return w;
    endfunction

endpackage

// File: rtl/vcap_ctrl_regs.sv
module vcap_ctrl_regs
    import vcap_irq_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int CTRL_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output ctrl_t             ctrl,
    output ctl_cmd_t          cmd
);

    localparam logic [ADDR_W-1:0] CTRL_SEL = ADDR_W'(CTRL_ADDR);

    logic ctl_wr;

    assign ctl_wr = reg_wr && (reg_addr == CTRL_SEL);

    // one-shot command bits are decoded straight from the write, never stored
    always_comb begin
        cmd.wr   = ctl_wr;
        cmd.ack  = ctl_wr ? reg_wdata[CTL_ACK_LSB +: NUM_EVT] : '0;
        cmd.srst = ctl_wr & reg_wdata[CTL_SRST_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (ctl_wr) begin
            ctrl <= unpack_ctrl(reg_wdata);
        end
    end

endmodule

// File: rtl/vcap_pos_track.sv
module vcap_pos_track
    import vcap_irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   srst,
    input  logic   pix_vld,
    input  coord_t pix_x,
    input  coord_t pix_y,
    input  logic   field_done,
    input  logic   wr_idle,
    input  coord_t y_thr,
    output pos_t   pos,
    output logic   thr_hit
);

    logic line_hit;   // threshold line seen in this field
    logic fired;      // threshold event already raised in this field

    assign thr_hit = line_hit & wr_idle & ~fired;

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            pos <= '0;
        end else if (pix_vld) begin
            pos.x <= pix_x;
            pos.y <= pix_y;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            line_hit <= 1'b0;
            fired    <= 1'b0;
        end else if (field_done) begin
            line_hit <= 1'b0;
            fired    <= 1'b0;
        end else begin
            if (pix_vld && (pix_y >= y_thr)) begin
                line_hit <= 1'b1;
            end
            if (thr_hit) begin
                fired <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/vcap_evt_flags.sv
module vcap_evt_flags
    import vcap_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     srst,
    input  evt_vec_t set,
    input  evt_vec_t ack,
    input  evt_vec_t ie,
    output evt_vec_t flags,
    output logic     irq
);

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst || srst) begin
                flags[i] <= 1'b0;
            end else if (set[i]) begin
                flags[i] <= 1'b1;     // a new occurrence outranks an acknowledge
            end else if (ack[i]) begin
                flags[i] <= 1'b0;
            end
        end
    end

    assign irq = |(flags & ie);

endmodule

// File: rtl/vcap_irq_unit.sv
module vcap_irq_unit
    import vcap_irq_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int CTRL_ADDR = 0,
    parameter int STAT_ADDR = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pix_vld,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic               field_done,
    input  logic               buf_ovf,
    input  logic               wr_idle,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq
);

    localparam logic [ADDR_W-1:0] CTRL_SEL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] STAT_SEL = ADDR_W'(STAT_ADDR);

    ctrl_t    ctrl;
    ctl_cmd_t cmd;
    pos_t     pos;
    logic     thr_hit;
    evt_vec_t evt_set;
    evt_vec_t evt_flags;

    vcap_ctrl_regs #(
        .ADDR_W   (ADDR_W),
        .CTRL_ADDR(CTRL_ADDR)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .ctrl     (ctrl),
        .cmd      (cmd)
    );

    vcap_pos_track u_pos (
        .clk       (clk),
        .rst       (rst),
        .srst      (cmd.srst),
        .pix_vld   (pix_vld),
        .pix_x     (pix_x),
        .pix_y     (pix_y),
        .field_done(field_done),
        .wr_idle   (wr_idle),
        .y_thr     (ctrl.y_thr),
        .pos       (pos),
        .thr_hit   (thr_hit)
    );

    always_comb begin
        evt_set         = '0;
        evt_set[EV_CC]  = field_done & ctrl.cap_en;
        evt_set[EV_THR] = thr_hit;
        evt_set[EV_HBE] = buf_ovf;
    end

    vcap_evt_flags u_flags (
        .clk  (clk),
        .rst  (rst),
        .srst (cmd.srst),
        .set  (evt_set),
        .ack  (cmd.ack),
        .ie   (ctrl.ie),
        .flags(evt_flags),
        .irq  (irq)
    );

    always_comb begin
        if (reg_addr == CTRL_SEL) begin
            reg_rdata = pack_ctrl(ctrl);
        end else if (reg_addr == STAT_SEL) begin
            reg_rdata = pack_status(evt_flags, pos);
        end else begin
            reg_rdata = '0;
        end
    end

endmodule

// File: rtl/vcap_irq_chk.sv
module vcap_irq_chk
    import vcap_irq_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input evt_vec_t flags,
    input evt_vec_t ie,
    input logic     irq,
    input logic     field_done,
    input logic     cap_en,
    input logic     wr_idle,
    input logic     buf_ovf,
    input evt_vec_t ack,
    input logic     srst,
    input pos_t     pos
);

    // R6
    irq_level_chk: assert property (@(posedge clk) disable iff (rst)
        irq == |(flags & ie));

    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ack[EV_HBE] && !buf_ovf |=> !flags[EV_HBE]);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        buf_ovf && !srst |=> flags[EV_HBE]);

    // R2
    cc_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !flags[EV_CC] && !(field_done && cap_en) |=> !flags[EV_CC]);

    // R3
    thr_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !flags[EV_THR] && !wr_idle |=> !flags[EV_THR]);

    // R9
    srst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        srst |=> (flags == '0) && (pos == '0));

endmodule

bind vcap_irq_unit vcap_irq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .flags     (evt_flags),
    .ie        (ctrl.ie),
    .irq       (irq),
    .field_done(field_done),
    .cap_en    (ctrl.cap_en),
    .wr_idle   (wr_idle),
    .buf_ovf   (buf_ovf),
    .ack       (cmd.ack),
    .srst      (cmd.srst),
    .pos       (pos)
);

// File: tb/sim_vcap_irq_unit.sv
module sim_vcap_irq_unit;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pix_vld = 1'b0;
    logic [11:0] pix_x = '0;
    logic [11:0] pix_y = '0;
    logic        field_done = 1'b0;
    logic        buf_ovf = 1'b0;
    logic        wr_idle = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    vcap_irq_unit u0 (
        .clk(clk), .rst(rst), .pix_vld(pix_vld), .pix_x(pix_x), .pix_y(pix_y),
        .field_done(field_done), .buf_ovf(buf_ovf), .wr_idle(wr_idle),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr_ctrl(input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pixel(input logic [11:0] x, input logic [11:0] y, input logic ovf);
        @(negedge clk);
        pix_vld = 1'b1; pix_x = x; pix_y = y; buf_ovf = ovf;
        @(negedge clk);
        pix_vld = 1'b0; buf_ovf = 1'b0;
    endtask

    task automatic fdone();
        @(negedge clk);
        field_done = 1'b1;
        @(negedge clk);
        field_done = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        rd(2'd0, d); chk("R1 ctrl after reset", d, 32'h0);
        rd(2'd1, d); chk("R1 status after reset", d, 32'h0);
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_ctrl();
        logic [31:0] d;
        wr_ctrl(32'h0800_007F);
        rd(2'd0, d); chk("R10 ctrl readback hides ack bits", d, 32'h0800_000F);
        wr_ctrl(32'h0800_0000);
    endtask

    task automatic t_position();
        logic [31:0] d;
        pixel(12'hABC, 12'h123, 1'b0);
        rd(2'd1, d); chk("R5 position field packing", d, 32'h0123_ABC0);
        pixel(12'hFFF, 12'h7FF, 1'b0);
        rd(2'd1, d); chk("R5 position all-ones column", d, 32'h07FF_FFF0);
    endtask

    task automatic t_capture();
        logic [31:0] d;
        fdone();
        rd(2'd1, d); chk("R2 no capture flag while disabled", d & 32'h7, 32'h0);
        wr_ctrl(32'h0800_0001);
        fdone();
        rd(2'd1, d); chk("R2 capture flag set when enabled", d & 32'h7, 32'h1);
        chk("R6 flag visible with enable off, irq low", {31'b0, irq}, 32'h0);
        wr_ctrl(32'h0800_0003);
        chk("R6 irq high once enabled", {31'b0, irq}, 32'h1);
        wr_ctrl(32'h0800_0013);
        rd(2'd1, d); chk("R7 ack clears capture flag", d & 32'h7, 32'h0);
        chk("R7 irq low next edge after ack", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_threshold();
        logic [31:0] d;
        wr_idle = 1'b0;
        wr_ctrl(32'h000A_0004);       // threshold 10, capture disabled
        pixel(12'd1, 12'd10, 1'b0);
        idle(3);
        rd(2'd1, d); chk("R3 threshold waits for write idle", d & 32'h7, 32'h0);
        wr_idle = 1'b1;
        idle(1);
        rd(2'd1, d); chk("R3 threshold set with capture disabled", d & 32'h7, 32'h2);
        chk("R3 threshold raises irq", {31'b0, irq}, 32'h1);
        wr_ctrl(32'h000A_0024);
        rd(2'd1, d); chk("R7 ack clears threshold flag", d & 32'h7, 32'h0);
        pixel(12'd2, 12'd11, 1'b0);
        idle(2);
        rd(2'd1, d); chk("R3 at most once per field", d & 32'h7, 32'h0);
        fdone();
        pixel(12'd3, 12'd12, 1'b0);
        idle(1);
        rd(2'd1, d); chk("R3 rearmed by field end", d & 32'h7, 32'h2);
        wr_ctrl(32'h000A_0024);
    endtask

    task automatic t_overflow();
        logic [31:0] d;
        wr_ctrl(32'h0FFF_000B);
        pixel(12'd5, 12'd2, 1'b1);
        rd(2'd1, d); chk("R4 overflow flag and position", d, 32'h0002_0054);
        chk("R4 overflow raises irq", {31'b0, irq}, 32'h1);
        wr_ctrl(32'h0FFF_000B);
        rd(2'd1, d); chk("R7 zero ack bit has no effect", d & 32'h7, 32'h4);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h0FFF_004B; buf_ovf = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; buf_ovf = 1'b0;
        rd(2'd1, d); chk("R8 event beats same-cycle ack", d & 32'h7, 32'h4);
        fdone();
        wr_ctrl(32'h0FFF_004B);
        rd(2'd1, d); chk("R7 ack overflow leaves capture flag", d & 32'h7, 32'h1);
        chk("R6 irq held by remaining enabled flag", {31'b0, irq}, 32'h1);
        wr_ctrl(32'h0FFF_001B);
        rd(2'd1, d); chk("R7 last ack clears flags", d & 32'h7, 32'h0);
        chk("R7 irq low after last ack", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_softreset();
        logic [31:0] d;
        pixel(12'd7, 12'd9, 1'b1);
        fdone();
        rd(2'd1, d); chk("R9 flags pending before soft reset", d, 32'h0009_0075);
        wr_ctrl(32'h0FFF_008B);
        rd(2'd1, d); chk("R9 soft reset clears status", d, 32'h0);
        chk("R9 soft reset drops irq", {31'b0, irq}, 32'h0);
        rd(2'd0, d); chk("R9 R10 control kept from same write", d, 32'h0FFF_000B);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_ctrl();
        t_position();
        t_capture();
        t_threshold();
        t_overflow();
        t_softreset();
        idle(2);
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule